// File: doc/BRIEF.md
# Sized Arithmetic/Logic Unit with Condition Flags

This block performs one integer operation per clock on 8, 16 or 32-bit operands and keeps a four-bit condition-flag register (negative, zero, overflow, carry) that later operations both consume and update. A datapath supplies a destination operand, a source operand, an operation code, a size select and, for increment/decrement, a step select. It qualifies the request with a valid strobe, and one clock later it reads a registered result together with a write-enable that says whether the result should go back to the destination.

The add, subtract and negate group produces carry/borrow and signed overflow. The increment/decrement group and the bitwise group leave carry alone. Compare only touches the flags. A flag-mask operation clears selected flags with an immediate mask. Operand bits above the selected size are ignored, and the result is returned zero-extended to 32 bits.

Top module: `cc_alu`

## Requirements
- R1: While reset is high and after it, until the first valid operation: result 0, write-enable 0, flags 0. The flag bus packs N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R2: The size select is 0 for byte, 1 for word, 2 or 3 for long. Operand bits above the size are ignored. The result is zero-extended. N is the top bit of the sized result, and Z is 1 exactly when the sized result is zero.
- R3: Opcode 0 (add) writes dst+src. C is the carry out of the sized top bit. V is 1 when both operands share a sign and the result's sign differs.
- R4: Opcode 1 (add with carry) writes dst+src+C. C and V follow R3, with V using the signs of dst and src.
- R5: Opcode 2 (subtract) writes dst-src and opcode 4 (negate) writes 0-src. C is the borrow (set when the unsigned minuend is below the subtrahend). V is 1 when the operand signs differ and the result's sign differs from the minuend's.
- R6: Opcode 3 (subtract with borrow) writes dst-src-C. C is the borrow of that whole subtraction, and V follows R5.
- R7: Opcode 5 (compare) sets all four flags exactly as subtract would. The write-enable stays low and the result output keeps its previous value.
- R8: Opcodes 6 and 7 (increment, decrement) add or subtract a step. The step is 1 for bytes. For word and long it is 2 when the step select is high, otherwise 1. V reports signed overflow (positive to negative on increment, negative to positive on decrement), and C is unchanged.
- R9: Opcodes 8, 9, 10 and 11 write dst AND src, dst OR src, dst XOR src, and src. They clear V and leave C unchanged.
- R10: Opcode 12 (flag mask) replaces the flags with the old flags ANDed with src[3:0] and raises no write-enable.
- R11: With the valid strobe low, or with opcodes 13 to 15, the flags and result hold and the write-enable is low.
- R12: Result, write-enable and flags change on the first clock edge after the inputs are presented with valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select |
| size_sel | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| step_two | input | 1 | Increment/decrement step of 2 for word and long |
| dst_opnd | input | 32 | Destination (first) operand |
| src_opnd | input | 32 | Source operand / flag mask |
| res_q | output | 32 | Registered result, zero-extended |
| res_we_q | output | 1 | Result should be written back |
| flags_q | output | 4 | Condition flags {N,Z,V,C} |

## Verification
The flag register feeds back into add-with-carry, subtract-with-borrow and the flag mask. A wrong internal flag value therefore appears on flags_q in the very next cycle, and it also corrupts the next carry-consuming result one cycle later. The bench keeps a behavioural reference of the flags and result, and compares all three outputs after every clock edge. Any single wrong bit in the carry, overflow or sized zero detection is reported within one cycle of the operation that exposes it. Directed corner values at each size are mixed with a long random stream in which flags chain from one operation to the next.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  localparam int DW   = 32;
  localparam int OPW  = 4;
  localparam int SZW  = 2;
  localparam int FLW  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBB = 4'd3,
    OP_NEG  = 4'd4,  OP_CMP  = 4'd5,  OP_INC  = 4'd6,  OP_DEC  = 4'd7,
    OP_AND  = 4'd8,  OP_OR   = 4'd9,  OP_XOR  = 4'd10, OP_MOV  = 4'd11,
    OP_FAND = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  function automatic logic [DW-1:0] size_mask(input logic [SZW-1:0] sz);
    case (sz)
      2'd0:    size_mask = DW'(8'hFF);
      2'd1:    size_mask = DW'(16'hFFFF);
      default: size_mask = '1;
    endcase
  endfunction

  function automatic logic sign_of(input logic [DW-1:0] x, input logic [SZW-1:0] sz);
    case (sz)
      2'd0:    sign_of = x[7];
      2'd1:    sign_of = x[15];
      default: sign_of = x[DW-1];
    endcase
  endfunction
endpackage

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub
  import cc_alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  input  logic           sub,
  input  logic [SZW-1:0] sz,
  output logic [W-1:0]   res,
  output logic           cout,
  output logic           ovf
);
  localparam int XW = W + 1;
  logic [XW-1:0] wide;
  logic sa, sb, sr;

  always_comb begin
    if (sub) wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    else     wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    res = wide[W-1:0] & size_mask(sz);
    case (sz)
      2'd0:    cout = wide[8];
      2'd1:    cout = wide[16];
      default: cout = wide[W];
    endcase
    sa  = sign_of(a, sz);
    sb  = sign_of(b, sz);
    sr  = sign_of(res, sz);
    ovf = sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  end
endmodule

// File: rtl/cc_alu_step.sv
module cc_alu_step
  import cc_alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0]   a,
  input  logic           dec,
  input  logic           step_two,
  input  logic [SZW-1:0] sz,
  output logic [W-1:0]   res,
  output logic           ovf
);
  logic [W-1:0] stp;
  logic sa, sr;

  always_comb begin
    stp = ((sz == 2'd0) || !step_two) ? W'(1) : W'(2);
    res = (dec ? (a - stp) : (a + stp)) & size_mask(sz);
    sa  = sign_of(a, sz);
    sr  = sign_of(res, sz);
    ovf = dec ? (sa && !sr) : (!sa && sr);
  end
endmodule

// File: rtl/cc_alu_logic.sv
module cc_alu_logic
  import cc_alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [OPW-1:0] op,
  output logic [W-1:0]   res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = b;
    endcase
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OPW-1:0]   op_code,
  input  logic [SZW-1:0]   size_sel,
  input  logic             step_two,
  input  logic [DW-1:0]    dst_opnd,
  input  logic [DW-1:0]    src_opnd,
  output logic [DW-1:0]    res_q,
  output logic             res_we_q,
  output logic [FLW-1:0]   flags_q
);
  flags_t        fl_q, fl_nx;
  logic [DW-1:0] a_m, b_m, as_a, as_res, st_res, lg_res, res_nx;
  logic          as_sub, as_cin, as_c, as_v, st_v, we_nx;

  assign a_m  = dst_opnd & size_mask(size_sel);
  assign b_m  = src_opnd & size_mask(size_sel);
  assign as_a = (op_code == OP_NEG) ? '0 : a_m;
  assign as_sub = (op_code == OP_SUB) || (op_code == OP_SUBB) ||
                  (op_code == OP_NEG) || (op_code == OP_CMP);
  assign as_cin = ((op_code == OP_ADDC) || (op_code == OP_SUBB)) ? fl_q.c : 1'b0;

  cc_alu_addsub #(.W(DW)) u_addsub (
    .a(as_a), .b(b_m), .cin(as_cin), .sub(as_sub), .sz(size_sel),
    .res(as_res), .cout(as_c), .ovf(as_v)
  );

  cc_alu_step #(.W(DW)) u_step (
    .a(a_m), .dec(op_code == OP_DEC), .step_two(step_two), .sz(size_sel),
    .res(st_res), .ovf(st_v)
  );

  cc_alu_logic #(.W(DW)) u_logic (
    .a(a_m), .b(b_m), .op(op_code), .res(lg_res)
  );

  always_comb begin
    fl_nx  = fl_q;
    res_nx = '0;
    we_nx  = 1'b0;
    case (op_code)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_NEG, OP_CMP: begin
        res_nx  = as_res;
        we_nx   = (op_code != OP_CMP);
        fl_nx.n = sign_of(as_res, size_sel);
        fl_nx.z = (as_res == '0);
        fl_nx.v = as_v;
        fl_nx.c = as_c;
      end
      OP_INC, OP_DEC: begin
        res_nx  = st_res;
        we_nx   = 1'b1;
        fl_nx.n = sign_of(st_res, size_sel);
        fl_nx.z = (st_res == '0);
        fl_nx.v = st_v;
      end
      OP_AND, OP_OR, OP_XOR, OP_MOV: begin
        res_nx  = lg_res;
        we_nx   = 1'b1;
        fl_nx.n = sign_of(lg_res, size_sel);
        fl_nx.z = (lg_res == '0);
        fl_nx.v = 1'b0;
      end
      OP_FAND: fl_nx = fl_q & flags_t'(src_opnd[FLW-1:0]);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_q     <= '0;
      res_q    <= '0;
      res_we_q <= 1'b0;
    end else begin
      res_we_q <= op_valid && we_nx;
      if (op_valid) begin
        fl_q <= fl_nx;
        if (we_nx) res_q <= res_nx;
      end
    end
  end

  assign flags_q = fl_q;

  assert_z_tracks_result_R2: assert property (@(posedge clk) disable iff (rst)
    res_we_q |-> (flags_q[2] == (res_q == '0)));

  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMP) |=> (!res_we_q && $stable(res_q)));

  assert_carry_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> $stable(flags_q[0]));

  assert_logic_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= OP_AND && op_code <= OP_MOV) |=> (!flags_q[1] && $stable(flags_q[0])));

  assert_flag_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_FAND) |=> (flags_q == ($past(flags_q) & $past(src_opnd[FLW-1:0]))));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(flags_q) && $stable(res_q) && !res_we_q));
endmodule

// File: tb/cc_alu_test.sv
`timescale 1ns/1ps
module cc_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [1:0]  size_sel = '0;
  logic        step_two = 1'b0;
  logic [31:0] dst_opnd = '0;
  logic [31:0] src_opnd = '0;
  logic [31:0] res_q;
  logic        res_we_q;
  logic [3:0]  flags_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0]  m_fl  = '0;
  logic [31:0] m_res = '0;
  logic        m_we  = 1'b0;

  always #2.5 clk = ~clk;

  cc_alu uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .size_sel(size_sel), .step_two(step_two), .dst_opnd(dst_opnd),
    .src_opnd(src_opnd), .res_q(res_q), .res_we_q(res_we_q), .flags_q(flags_q)
  );

  function automatic string tag_of(input logic v, input logic [3:0] op);
    if (!v || op > 4'd12) return "R11";
    case (op)
      4'd0: return "R3";  4'd1: return "R4";  4'd2, 4'd4: return "R5";
      4'd3: return "R6";  4'd5: return "R7";  4'd6, 4'd7: return "R8";
      4'd12: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] er, input logic ew, input logic [3:0] ef);
    checks++;
    if (res_q !== er || res_we_q !== ew || flags_q !== ef) begin
      fails++;
      $display("FAIL %s: res=%h we=%b flags=%b expected res=%h we=%b flags=%b (R12 timing)",
               req, res_q, res_we_q, flags_q, er, ew, ef);
    end
  endtask

  // Reference model, then one clock, then compare.
  task automatic apply(input logic v, input logic [3:0] op, input logic [1:0] sz,
                       input logic [31:0] d, input logic [31:0] s, input logic st2);
    longint w, mask, a, b, aa, r, x;
    logic n_, z_, v_, c_;
    logic [3:0] nf;
    logic [31:0] nr;
    logic nw;
    op_valid = v; op_code = op; size_sel = sz; dst_opnd = d; src_opnd = s; step_two = st2;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (longint'(1) << w) - 1;
    a = longint'(d) & mask; b = longint'(s) & mask;
    nf = m_fl; nr = m_res; nw = 1'b0;
    r = 0; v_ = m_fl[1]; c_ = m_fl[0];
    if (v && op <= 4'd11) begin
      if (op <= 4'd1) begin
        x = a + b + ((op == 4'd1) ? longint'(m_fl[0]) : 0);
        r = x & mask; c_ = x[w];
        v_ = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
      end else if (op <= 4'd5) begin
        aa = (op == 4'd4) ? 0 : a;
        x = aa - b - ((op == 4'd3) ? longint'(m_fl[0]) : 0);
        r = x & mask; c_ = (x < 0);
        v_ = (aa[w-1] != b[w-1]) && (r[w-1] != aa[w-1]);
      end else if (op <= 4'd7) begin
        x = (sz == 0 || !st2) ? 1 : 2;
        r = ((op == 4'd6) ? a + x : a - x) & mask;
        v_ = (op == 4'd6) ? (!a[w-1] && r[w-1]) : (a[w-1] && !r[w-1]);
      end else begin
        case (op)
          4'd8: r = a & b;  4'd9: r = a | b;  4'd10: r = a ^ b;
          default: r = b;
        endcase
        v_ = 1'b0;
      end
      n_ = r[w-1]; z_ = (r == 0);
      nf = {n_, z_, v_, c_};
      nw = (op != 4'd5);
      if (nw) nr = 32'(r);
    end else if (v && op == 4'd12) begin
      nf = m_fl & s[3:0];
    end
    @(posedge clk); #1;
    check(tag_of(v, op), nr, nw, nf);
    m_fl = nf; m_res = nr; m_we = nw;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1", 32'h0, 1'b0, 4'b0000);
    // R3 byte: 7F+01 overflow, N set
    apply(1, 4'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 0);
    // R3/R2 byte wrap to zero with carry, upper bits ignored
    apply(1, 4'd0, 2'd0, 32'hABCD_EFFF, 32'h1234_5601, 0);
    // R4 add with carry consumes C=1
    apply(1, 4'd1, 2'd1, 32'h0000_1000, 32'h0000_0010, 0);
    // R3 long carry out
    apply(1, 4'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0002, 0);
    // R5 subtract 0-1 word: borrow
    apply(1, 4'd2, 2'd1, 32'h0000_0000, 32'h0000_0001, 0);
    // R6 subtract with borrow
    apply(1, 4'd3, 2'd0, 32'h0000_0010, 32'h0000_0005, 0);
    // R5 negate most-negative byte: overflow
    apply(1, 4'd4, 2'd0, 32'h0, 32'h0000_0080, 0);
    // R7 compare equal: Z set, no write
    apply(1, 4'd5, 2'd3, 32'h5555_AAAA, 32'h5555_AAAA, 0);
    // R8 word increment 7FFF step 1 and step 2
    apply(1, 4'd6, 2'd1, 32'h0000_7FFF, 32'h0, 0);
    apply(1, 4'd6, 2'd1, 32'h0000_7FFE, 32'h0, 1);
    // R8 byte decrement 80 ignores step select
    apply(1, 4'd7, 2'd0, 32'h0000_0080, 32'h0, 1);
    // R9 logic ops
    apply(1, 4'd8, 2'd2, 32'hF0F0_F0F0, 32'h8F00_000F, 0);
    apply(1, 4'd10, 2'd1, 32'h0000_1234, 32'h0000_1234, 0);
    apply(1, 4'd11, 2'd0, 32'hFFFF_FFFF, 32'h0000_0181, 0);
    // R10 flag mask
    apply(1, 4'd0, 2'd0, 32'h80, 32'h80, 0);
    apply(1, 4'd12, 2'd0, 32'h0, 32'h0000_00F5, 0);
    // R11 invalid strobe and unused opcode
    apply(0, 4'd0, 2'd0, 32'h1, 32'h1, 0);
    apply(1, 4'd14, 2'd2, 32'h7, 32'h9, 0);
    // Random chained stream
    for (int i = 0; i < 2000; i++) begin
      apply(($urandom % 8) != 0, 4'($urandom % 16), 2'($urandom % 4),
            $urandom, ((i % 5) == 0) ? 32'h0 : $urandom, 1'($urandom % 2));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule